// File: doc/BRIEF.md
# Retransmit-Capable FIFO Read Controller

This block drives the read side of a synchronous FIFO whose output is registered. It holds the read pointer, addresses the storage array, loads the output register, and reports when nothing is left to read. The write side runs on the same clock and hands its write pointer in. That pointer is one bit wider than the array index, and the extra top bit acts as a lap flag.

Data already consumed can be played back. Pulling the active-low retransmit input low at a clock edge rewinds the read pointer to array location zero. A latency choice, sampled only while master reset is high, decides when the first replayed word appears. In zero-latency mode the word at location zero is loaded on the same edge that sees the request. In normal mode the output register keeps its value, and location zero arrives on the next accepted read. The storage array is read combinationally, so the word at the address presented in a cycle is available at that cycle's edge.

Top module: `rdp_top`

## Requirements
- R1: While `rst` is high at a clock edge, the read pointer and `dout` clear to zero and `lat_sel` is captured as the latency mode (0 = zero latency, 1 = normal latency). After reset, `empty` is high when `wr_ptr` is zero.
- R2: At an edge where `rt_n` is high, `rd_en` is high and `empty` is low, `dout` takes the word at the current read index and the read pointer advances by one. The index wraps from DEPTH-1 back to 0 and the lap bit toggles.
- R3: A read request while `empty` is high has no effect: `dout` keeps its value and the read pointer does not move, so the next word written is the next word read.
- R4: `rt_n` low at a rising edge starts a retransmit, and this takes priority over a simultaneous `rd_en`.
- R5: In zero-latency mode, a retransmit with data present puts the word at location 0 into `dout` on the same edge, and the following read returns location 1.
- R6: In normal-latency mode, `dout` holds its value across the retransmit edge, and the next accepted read returns the word at location 0.
- R7: After a rewind, `empty` is recomputed from the rewound pointer against `wr_ptr`. The occupancy counts the words from location 0 up to the write index. A write index of 0 with lap bit 1 means a full array of DEPTH words.
- R8: Changes on `lat_sel` while `rst` is low do not alter the latency mode.
- R9: A zero-latency retransmit while `wr_ptr` is zero leaves `dout` unchanged and `empty` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high master reset |
| rd_en | input | 1 | Read request |
| rt_n | input | 1 | Active-low retransmit request |
| lat_sel | input | 1 | Latency mode, sampled during reset (0 zero, 1 normal) |
| wr_ptr | input | ADDR_W+1 | Write pointer from the write side; the top bit is the lap flag |
| mem_raddr | output | ADDR_W | Storage array read address |
| mem_rdata | input | DATA_W | Storage array read data, combinational from `mem_raddr` |
| dout | output | DATA_W | Registered output word |
| empty | output | 1 | High when the read pointer equals the write pointer |

## Verification
The assertions assume that `wr_ptr` never runs more than DEPTH words ahead of the read pointer. They also assume that the storage array returns the word at `mem_raddr` within the same cycle, and that replay only happens while the words written since reset fit in one array. The bench models the write side itself: it writes words into its own array and advances the write pointer only at falling edges, and it never writes more than DEPTH words beyond the last read. Every word, including the full-array case, is written starting from location 0 after a reset, so each rewind finds exactly the data it is meant to replay.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    typedef enum logic {
        LAT_ZERO   = 1'b0,
        LAT_NORMAL = 1'b1
    } lat_mode_e;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_READ    = 2'd1,
        OP_RT_LOAD = 2'd2,
        OP_RT_ONLY = 2'd3
    } rd_op_e;

    // Lap bit for a pointer rewound to index zero: an exhausted write
    // index means the array is full (or empty when nothing was written).
    function automatic logic rewind_lap(input logic wr_lap, input logic wr_idx_zero);
        return wr_idx_zero ? 1'b0 : wr_lap;
    endfunction

    function automatic logic loads_output(input rd_op_e op);
        return (op == OP_READ) || (op == OP_RT_LOAD);
    endfunction

endpackage

// File: rtl/rdp_ctrl.sv
module rdp_ctrl
    import rdp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rd_en,
    input  logic      rt_n,
    input  logic      lat_sel,
    input  logic      empty,
    input  logic      wr_nonzero,
    output lat_mode_e mode,
    output rd_op_e    op
);

    lat_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= lat_mode_e'(lat_sel);
        end
    end

    always_comb begin
        op = OP_IDLE;
        if (rst) begin
            op = OP_IDLE;
        end else if (!rt_n) begin
            if (mode_q == LAT_ZERO && wr_nonzero) begin
                op = OP_RT_LOAD;
            end else begin
                op = OP_RT_ONLY;
            end
        end else if (rd_en && !empty) begin
            op = OP_READ;
        end
    end

    assign mode = mode_q;

    // R8: the latency mode only moves under reset
    assert_mode_fixed_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mode_q));

endmodule

// File: rtl/rdp_ptr.sv
module rdp_ptr
    import rdp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_op_e            op,
    input  logic [ADDR_W:0]   wr_ptr,
    output logic [ADDR_W:0]   rd_ptr,
    output logic [ADDR_W-1:0] raddr,
    output logic              empty
);

    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 2 ** ADDR_W;

    logic [PW-1:0] rd_q;
    logic [PW-1:0] rewind_ptr;
    logic [PW-1:0] occ;

    assign rewind_ptr = {rewind_lap(wr_ptr[ADDR_W], wr_ptr[ADDR_W-1:0] == '0),
                         {ADDR_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            unique case (op)
                OP_READ:    rd_q <= rd_q + PW'(1);
                OP_RT_LOAD: rd_q <= rewind_ptr + PW'(1);
                OP_RT_ONLY: rd_q <= rewind_ptr;
                default:    rd_q <= rd_q;
            endcase
        end
    end

    assign raddr  = (op == OP_RT_LOAD) ? '0 : rd_q[ADDR_W-1:0];
    assign empty  = (rd_q == wr_ptr);
    assign rd_ptr = rd_q;
    assign occ    = wr_ptr - rd_q;

    // R2: an accepted read moves the pointer by exactly one
    assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_READ) |=> (rd_q == $past(rd_q) + PW'(1)));

    // R5: a zero-latency replay leaves the pointer at location 1
    assert_replay_next_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RT_LOAD) |=> (rd_q[ADDR_W-1:0] == ADDR_W'(1)));

    // R7: the read side never falls behind by more than a full array
    assert_occ_bound_R7: assert property (@(posedge clk) disable iff (rst)
        occ <= PW'(DEPTH));

endmodule

// File: rtl/rdp_outreg.sv
module rdp_outreg
    import rdp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_op_e            op,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (loads_output(op)) begin
            dout <= mem_rdata;
        end
    end

    // R3: no accepted read, no change at the output
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE) |=> $stable(dout));

    // R6: normal-latency rewind keeps the output register
    assert_rt_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RT_ONLY) |=> $stable(dout));

    // R5: zero-latency rewind loads the addressed word on the same edge
    assert_zero_lat_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RT_LOAD) |=> (dout == $past(mem_rdata)));

endmodule

// File: rtl/rdp_top.sv
module rdp_top
    import rdp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              rt_n,
    input  logic              lat_sel,
    input  logic [ADDR_W:0]   wr_ptr,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] dout,
    output logic              empty
);

    lat_mode_e         mode;
    rd_op_e            op;
    logic [ADDR_W:0]   rd_ptr;
    logic              empty_w;

    rdp_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .rt_n       (rt_n),
        .lat_sel    (lat_sel),
        .empty      (empty_w),
        .wr_nonzero (wr_ptr != '0),
        .mode       (mode),
        .op         (op)
    );

    rdp_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .raddr  (mem_raddr),
        .empty  (empty_w)
    );

    rdp_outreg #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .mem_rdata (mem_rdata),
        .dout      (dout)
    );

    assign empty = empty_w;

    // R4: a retransmit request always rewinds, whatever rd_en says
    assert_rt_priority_R4: assert property (@(posedge clk) disable iff (rst)
        !rt_n |=> (rd_ptr[ADDR_W-1:0] <= ADDR_W'(1)));

    // R9: zero-latency replay with nothing written stays empty
    assert_empty_replay_R9: assert property (@(posedge clk) disable iff (rst)
        (!rt_n && wr_ptr == '0 && mode == LAT_ZERO) |=> ($stable(dout) && empty));

endmodule

// File: tb/rdp_top_tb_top.sv
module rdp_top_tb_top;

    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int PW    = AW + 1;
    localparam int DEPTH = 2 ** AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_en = 1'b0;
    logic          rt_n = 1'b1;
    logic          lat_sel = 1'b0;
    logic [PW-1:0] wr_ptr = '0;
    logic [AW-1:0] mem_raddr;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] dout;
    logic          empty;

    logic [DW-1:0] mem [DEPTH];
    assign mem_rdata = mem[mem_raddr];

    always #2 clk = ~clk;

    rdp_top #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .rt_n      (rt_n),
        .lat_sel   (lat_sel),
        .wr_ptr    (wr_ptr),
        .mem_raddr (mem_raddr),
        .mem_rdata (mem_rdata),
        .dout      (dout),
        .empty     (empty)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference model state
    logic [PW-1:0] m_rd;
    logic          m_lat;
    logic [DW-1:0] m_dout;

    typedef struct {
        logic [DW-1:0] d;
        logic          e;
        string         req;
    } exp_t;

    exp_t sbq[$];
    bit   pend = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: compares the design against queued expectations after each edge
    always @(posedge clk) begin
        #1;
        if (pend) begin
            exp_t it;
            pend = 0;
            it = sbq.pop_front();
            chk(dout == it.d, {it.req, " dout"}, int'(dout), int'(it.d));
            chk(empty == it.e, {it.req, " empty"}, int'(empty), int'(it.e));
        end
    end

    task automatic do_reset(input bit lat);
        @(negedge clk);
        rst = 1'b1; lat_sel = lat; rd_en = 1'b0; rt_n = 1'b1; wr_ptr = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_rd = '0; m_dout = '0; m_lat = lat;
        chk(dout == '0, "R1 dout cleared", int'(dout), 0);
        chk(empty == 1'b1, "R1 empty after reset", int'(empty), 1);
    endtask

    task automatic put_word(input logic [DW-1:0] v);
        @(negedge clk);
        mem[wr_ptr[AW-1:0]] = v;
        wr_ptr = wr_ptr + PW'(1);
    endtask

    // driver: applies one request, predicts the outcome and queues it
    task automatic step(input bit en, input bit rt, input string req);
        logic [PW-1:0] rew;
        @(negedge clk);
        rd_en = en; rt_n = !rt;
        if (rt) begin
            rew = {(wr_ptr[AW-1:0] == '0) ? 1'b0 : wr_ptr[AW], {AW{1'b0}}};
            if (!m_lat && wr_ptr != '0) begin
                m_dout = mem[0];
                m_rd = rew + PW'(1);
            end else begin
                m_rd = rew;
            end
        end else if (en && m_rd != wr_ptr) begin
            m_dout = mem[m_rd[AW-1:0]];
            m_rd = m_rd + PW'(1);
        end
        sbq.push_back('{d: m_dout, e: (m_rd == wr_ptr), req: req});
        pend = 1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0; rt_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;

        // zero-latency mode
        do_reset(1'b0);
        step(1'b1, 1'b0, "R3 read while empty");
        put_word(8'h11);
        step(1'b1, 1'b0, "R3 pointer unmoved, first word");
        chk(dout == 8'h11, "R3 explicit first word", int'(dout), 'h11);
        for (int i = 0; i < 4; i++) put_word(8'h20 + 8'(i));
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R2 sequential read");
        step(1'b1, 1'b0, "R3 read past last word");
        step(1'b1, 1'b1, "R4 R5 retransmit with rd_en");
        chk(dout == 8'h11, "R5 explicit replay word", int'(dout), 'h11);
        step(1'b1, 1'b0, "R5 read after replay");
        chk(dout == 8'h20, "R5 explicit location 1", int'(dout), 'h20);
        step(1'b0, 1'b0, "R7 idle after replay");

        // latency pin moved outside reset must not matter
        @(negedge clk); lat_sel = 1'b1;
        step(1'b0, 1'b1, "R8 still zero latency");
        chk(dout == 8'h11, "R8 explicit replay word", int'(dout), 'h11);

        // normal-latency mode
        do_reset(1'b1);
        for (int i = 0; i < 3; i++) put_word(8'h40 + 8'(i));
        step(1'b1, 1'b0, "R2 read normal mode");
        step(1'b1, 1'b0, "R2 read normal mode");
        step(1'b0, 1'b1, "R6 retransmit holds output");
        chk(dout == 8'h41, "R6 explicit held word", int'(dout), 'h41);
        step(1'b1, 1'b0, "R6 first read after replay");
        chk(dout == 8'h40, "R6 explicit location 0", int'(dout), 'h40);
        step(1'b1, 1'b0, "R6 second read after replay");
        step(1'b1, 1'b0, "R7 drain after replay");
        step(1'b1, 1'b0, "R3 empty after drain");

        // zero latency with nothing written
        do_reset(1'b0);
        step(1'b1, 1'b1, "R9 replay with no data");
        chk(empty == 1'b1, "R9 explicit empty", int'(empty), 1);

        // full array, wrap, and full-lap rewind
        for (int i = 0; i < DEPTH; i++) put_word(8'h80 + 8'(i));
        chk(empty == 1'b0, "R7 full array not empty", int'(empty), 0);
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, "R2 full drain with wrap");
        chk(empty == 1'b1, "R2 empty after wrap", int'(empty), 1);
        step(1'b0, 1'b1, "R7 rewind on full lap");
        chk(empty == 1'b0, "R7 explicit non-empty after full rewind", int'(empty), 0);
        for (int i = 1; i < DEPTH; i++) step(1'b1, 1'b0, "R7 replay remainder");
        chk(dout == 8'h80 + 8'(DEPTH - 1), "R7 explicit last word", int'(dout), 'h80 + DEPTH - 1);
        chk(empty == 1'b1, "R7 explicit empty after replay", int'(empty), 1);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(4 * 50000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule